// File: doc/BRIEF.md
# Ring-Accumulating Multiply Cell

This cell multiplies two signed fixed-point operands per accepted cycle and adds the exact product into one register of a small ring of accumulators. The target register advances one step per accepted product. Consecutive products therefore land in different registers, and an adder with several pipeline stages could take a new product on every cycle without a read-after-write stall. The sum of all ring registers is the dot product of the stream. That final cross-register sum is left to the consumer.

A pass starts with a clear, which zeroes the ring and sends the slot pointer back to register 0. Operand pairs are then streamed with a valid strobe. A drain request ends the pass. The cell stops taking operands and waits until its two internal pipeline stages are empty. It then presents the ring registers one per cycle, lowest index first, with a valid flag and a last flag.

Top module: `mac_ring_cell`

## Requirements
- R1: After reset, `res_valid` and `res_last` are low and every ring register holds zero, so a drain issued straight after reset returns RING_LEN zeros.
- R2: Operands are two's-complement signed values of OP_W bits, and each product is kept at its full 2*OP_W bits. The extreme case (-2^(OP_W-1)) * (-2^(OP_W-1)) = +2^(2*OP_W-2) is accumulated exactly.
- R3: Counting accepted products from 0 after the last clear, product number n is added to ring register n mod RING_LEN.
- R4: A cycle with `in_valid` low changes no ring register.
- R5: `clr` high zeroes every ring register and resets the slot pointer to 0. An operand pair offered in the same cycle, and any product still in the pipeline, is discarded.
- R6: A `drain_start` sampled at clock edge e while the cell is idle starts a drain. Let k be the edge of the last accepted operand pair, or -infinity if there was none. Then `res_valid` is high for the RING_LEN cycles that follow edges f .. f+RING_LEN-1, where f = max(e+1, k+3). During those cycles `res_data` carries ring registers 0, 1, ..., RING_LEN-1 in that order, and `res_last` is high only with register RING_LEN-1.
- R7: From the edge after `drain_start` is taken until the edge after the last drain word (edges e+1 .. f+RING_LEN), `in_valid` and `drain_start` are ignored. An operand pair offered together with the accepted `drain_start` at edge e is still accepted.
- R8: A drain does not alter the ring or the slot pointer. Products accepted after a drain continue at the next slot, on top of the values already held.
- R9: Accumulators are 2*OP_W+GUARD_W bits wide. No sum of products overflows while at most 2^GUARD_W full-scale products are accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Start of pass: zero ring, pointer and pipeline |
| in_valid | input | 1 | Operand pair present on `a_in`/`b_in` |
| a_in | input | OP_W | Signed operand A |
| b_in | input | OP_W | Signed operand B |
| drain_start | input | 1 | Request to read out the ring |
| res_valid | output | 1 | `res_data` holds a ring register |
| res_last | output | 1 | Current word is the last ring register |
| res_data | output | 2*OP_W+GUARD_W | Ring register contents, signed |

## Verification
The internal checks assume that `clr` is not raised while a drain is pending or running. They also assume that no more than 2^GUARD_W full-scale products are accumulated in one pass, since the overflow guard relies on that bound. The stimulus keeps to both conditions. It raises `clr` only between drains and pushes at most a few hundred products per pass, including runs of the most negative operand. It does offer operands and repeated drain requests while a drain is pending or running, which checks that they are dropped rather than avoided.

// File: rtl/mac_ring_pkg.sv
// Package: shared types and helpers for the ring-accumulating multiply cell.
// Assumes: nothing beyond IEEE 1800-2017 semantics.
package mac_ring_pkg;

    // Drain controller phases.
    typedef enum logic [1:0] {
        DR_IDLE  = 2'd0,   // accepting operands
        DR_WAIT  = 2'd1,   // drain requested, pipeline still busy
        DR_SHIFT = 2'd2    // presenting ring registers
    } drain_state_e;

    // Width of an index into a ring of n registers (at least one bit).
    function automatic int ring_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mac_operand_stage.sv
// Module: mac_operand_stage
// Registers an accepted operand pair, then registers its full-width signed
// product one cycle later. The two valid bits together form the pipeline
// occupancy flag used by the drain controller.
// Assumes: accept_en low stops new pairs; clr flushes both stages.
module mac_operand_stage #(
    parameter int OP_W   = 16,
    parameter int PROD_W = 2 * OP_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     accept_en,
    input  logic                     in_valid,
    input  logic signed [OP_W-1:0]   a_in,
    input  logic signed [OP_W-1:0]   b_in,
    output logic                     prod_valid,
    output logic signed [PROD_W-1:0] prod,
    output logic                     pipe_busy
);

    logic                   cap_v_q;
    logic signed [OP_W-1:0] a_q;
    logic signed [OP_W-1:0] b_q;
    logic                   take;

    assign take = in_valid && accept_en;

    // Capture stage: hold the operand pair of an accepted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cap_v_q <= 1'b0;
            a_q     <= '0;
            b_q     <= '0;
        end else begin
            cap_v_q <= take;
            if (take) begin
                a_q <= a_in;
                b_q <= b_in;
            end
        end
    end

    // Product stage: exact signed product of the captured pair.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prod_valid <= 1'b0;
            prod       <= '0;
        end else begin
            prod_valid <= cap_v_q;
            if (cap_v_q) begin
                prod <= PROD_W'(a_q * b_q);
            end
        end
    end

    // Occupancy: either stage still holds an unfinished item.
    assign pipe_busy = cap_v_q || prod_valid;

    // R7: with acceptance closed, no pair enters the capture stage.
    assert_gate_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_en && !clr) |=> !cap_v_q);

    // R5: a clear leaves the pipeline empty.
    assert_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pipe_busy);

endmodule

// File: rtl/mac_acc_ring.sv
// Module: mac_acc_ring
// A ring of RING_LEN signed accumulators. Each valid product is added into
// the register the slot pointer selects, and the pointer then advances
// modulo RING_LEN. A read port picks any register for the drain.
// Assumes: products are sign-extended here, and the caller keeps the
// accumulation count within the guard-bit budget.
module mac_acc_ring #(
    parameter int RING_LEN = 4,
    parameter int PROD_W   = 32,
    parameter int ACC_W    = 56,
    parameter int IDX_W    = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     add_en,
    input  logic signed [PROD_W-1:0] prod,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic signed [ACC_W-1:0]  rd_data
);

    localparam int EXT_W = ACC_W - PROD_W;
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(RING_LEN - 1);

    logic [RING_LEN-1:0][ACC_W-1:0] acc_q;
    logic [IDX_W-1:0]               ptr_q;
    logic signed [ACC_W-1:0]        prod_ext;
    logic signed [ACC_W-1:0]        sel_acc;
    logic [ACC_W:0]                 sum_chk;

    assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};

    // Slot pointer: advances once per accepted product, wraps at the ring end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr_q <= '0;
        end else if (add_en) begin
            ptr_q <= (ptr_q == LAST_SLOT) ? '0 : ptr_q + 1'b1;
        end
    end

    // One accumulator per ring position, each updated only when selected.
    for (genvar g = 0; g < RING_LEN; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                acc_q[g] <= '0;
            end else if (add_en && (ptr_q == IDX_W'(g))) begin
                acc_q[g] <= ACC_W'($signed(acc_q[g]) + prod_ext);
            end
        end
    end

    // Drain read port: combinational select of one register.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < RING_LEN; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = $signed(acc_q[i]);
            end
        end
    end

    // Overflow monitor input: one-bit-wider sum of the selected slot.
    always_comb begin
        sel_acc = '0;
        for (int i = 0; i < RING_LEN; i++) begin
            if (ptr_q == IDX_W'(i)) begin
                sel_acc = $signed(acc_q[i]);
            end
        end
        sum_chk = {sel_acc[ACC_W-1], sel_acc} + {prod_ext[ACC_W-1], prod_ext};
    end

    // R9: the guard bits absorb every sum within the accumulation budget.
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        add_en |-> (sum_chk[ACC_W] == sum_chk[ACC_W-1]));

    // R4: without a product the ring holds its values.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!add_en && !clr) |=> $stable(acc_q));

    // R5: a clear zeroes the ring and the slot pointer.
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((acc_q == '0) && (ptr_q == '0)));

    // R3: each product moves the pointer to the next slot, wrapping at the end.
    assert_round_robin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !clr) |=> (ptr_q == (($past(ptr_q) == LAST_SLOT) ? '0 : $past(ptr_q) + 1'b1)));

endmodule

// File: rtl/mac_drain_ctrl.sv
// Module: mac_drain_ctrl
// Sequences a drain. A request taken while idle closes operand acceptance,
// waits for the product pipeline to empty, then steps a read index over
// every ring register, one per cycle, flagging the last one.
// Assumes: clr is not raised during a drain (if it is, the drain is abandoned).
module mac_drain_ctrl
    import mac_ring_pkg::*;
#(
    parameter int RING_LEN = 4,
    parameter int IDX_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             drain_start,
    input  logic             pipe_busy,
    output logic             accept_en,
    output logic [IDX_W-1:0] rd_idx,
    output logic             res_valid,
    output logic             res_last
);

    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(RING_LEN - 1);

    drain_state_e     state_q;
    logic [IDX_W-1:0] idx_q;

    // Phase and read-index sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state_q <= DR_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                DR_IDLE: begin
                    if (drain_start) begin
                        state_q <= DR_WAIT;
                    end
                end
                DR_WAIT: begin
                    if (!pipe_busy) begin
                        state_q <= DR_SHIFT;
                        idx_q   <= '0;
                    end
                end
                DR_SHIFT: begin
                    if (idx_q == LAST_SLOT) begin
                        state_q <= DR_IDLE;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= DR_IDLE;
                end
            endcase
        end
    end

    // Output decode from the registered phase.
    assign accept_en = (state_q == DR_IDLE);
    assign rd_idx    = idx_q;
    assign res_valid = (state_q == DR_SHIFT);
    assign res_last  = (state_q == DR_SHIFT) && (idx_q == LAST_SLOT);

    // R6: the last flag only marks a valid word.
    assert_last_in_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_last |-> res_valid);

    // R6: the burst ends right after the last word.
    assert_burst_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_last && !clr) |=> !res_valid);

    // R6: consecutive valid words step the index by one.
    assert_index_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_last && !clr) |=> (res_valid && (rd_idx == $past(rd_idx) + 1'b1)));

endmodule

// File: rtl/mac_ring_cell.sv
// Module: mac_ring_cell (top)
// Multiply-accumulate cell with a ring of accumulators. Operands pass
// through a capture and a product stage, products are spread round-robin
// over RING_LEN accumulators, and a drain reads the ring out one register
// per cycle. The consumer adds the drained words to form the result.
// Assumes: at most 2^GUARD_W full-scale products per pass; clr only while idle.
module mac_ring_cell #(
    parameter int OP_W     = 16,
    parameter int RING_LEN = 4,
    parameter int GUARD_W  = 24
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clr,
    input  logic                                 in_valid,
    input  logic signed [OP_W-1:0]               a_in,
    input  logic signed [OP_W-1:0]               b_in,
    input  logic                                 drain_start,
    output logic                                 res_valid,
    output logic                                 res_last,
    output logic signed [2*OP_W+GUARD_W-1:0]     res_data
);

    localparam int PROD_W = 2 * OP_W;
    localparam int ACC_W  = PROD_W + GUARD_W;
    localparam int IDX_W  = mac_ring_pkg::ring_idx_w(RING_LEN);

    logic                     accept_en;
    logic                     prod_valid;
    logic signed [PROD_W-1:0] prod;
    logic                     pipe_busy;
    logic [IDX_W-1:0]         rd_idx;

    mac_operand_stage #(
        .OP_W   (OP_W),
        .PROD_W (PROD_W)
    ) u_ops (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .accept_en  (accept_en),
        .in_valid   (in_valid),
        .a_in       (a_in),
        .b_in       (b_in),
        .prod_valid (prod_valid),
        .prod       (prod),
        .pipe_busy  (pipe_busy)
    );

    mac_acc_ring #(
        .RING_LEN (RING_LEN),
        .PROD_W   (PROD_W),
        .ACC_W    (ACC_W),
        .IDX_W    (IDX_W)
    ) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .add_en  (prod_valid),
        .prod    (prod),
        .rd_idx  (rd_idx),
        .rd_data (res_data)
    );

    mac_drain_ctrl #(
        .RING_LEN (RING_LEN),
        .IDX_W    (IDX_W)
    ) u_drain (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .drain_start (drain_start),
        .pipe_busy   (pipe_busy),
        .accept_en   (accept_en),
        .rd_idx      (rd_idx),
        .res_valid   (res_valid),
        .res_last    (res_last)
    );

    // R6: words are presented only once the product pipeline is empty.
    assert_drain_after_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !pipe_busy);

    // R1: the first cycle out of reset shows no result word.
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!res_valid && !res_last));

endmodule

// File: tb/sim_mac_ring_cell.sv
// Bench for mac_ring_cell. A behavioural model tracks per-slot sums and the
// expected drain window, and the outputs are compared on every clock.
module sim_mac_ring_cell;

    localparam int OP_W     = 16;
    localparam int RING_LEN = 4;
    localparam int GUARD_W  = 24;
    localparam int ACC_W    = 2 * OP_W + GUARD_W;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    clr = 1'b0;
    logic                    in_valid = 1'b0;
    logic signed [OP_W-1:0]  a_in = '0;
    logic signed [OP_W-1:0]  b_in = '0;
    logic                    drain_start = 1'b0;
    logic                    res_valid;
    logic                    res_last;
    logic signed [ACC_W-1:0] res_data;

    int checks = 0;
    int fails  = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    mac_ring_cell #(
        .OP_W     (OP_W),
        .RING_LEN (RING_LEN),
        .GUARD_W  (GUARD_W)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .in_valid    (in_valid),
        .a_in        (a_in),
        .b_in        (b_in),
        .drain_start (drain_start),
        .res_valid   (res_valid),
        .res_last    (res_last),
        .res_data    (res_data)
    );

    // ---------------- reference model ----------------
    longint sums [RING_LEN];
    int     cnt;
    int     cyc;
    int     last_acc;
    bit     busy;
    int     m_e;
    int     m_f;
    bit     started = 1'b0;
    bit     exp_valid;
    bit     exp_last;
    longint exp_data;

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            foreach (sums[i]) sums[i] = 0;
            cnt = 0; cyc = 0; last_acc = -100; busy = 0; m_e = 0; m_f = 0;
            exp_valid = 0; exp_last = 0; exp_data = 0;
        end else begin
            bit blocked;
            cyc++;
            blocked = busy && (cyc > m_e) && (cyc <= m_f + RING_LEN);
            if (clr) begin
                foreach (sums[i]) sums[i] = 0;
                cnt = 0; last_acc = -100; busy = 0;
            end else begin
                if (in_valid && !blocked) begin
                    sums[cnt % RING_LEN] += longint'(a_in) * longint'(b_in);
                    cnt++;
                    last_acc = cyc;
                end
                if (drain_start && !blocked && !busy) begin
                    busy = 1;
                    m_e  = cyc;
                    m_f  = (cyc + 1 > last_acc + 3) ? cyc + 1 : last_acc + 3;
                end
            end
            if (busy && cyc >= m_f + RING_LEN) busy = 0;
            exp_valid = busy && (cyc >= m_f) && (cyc <= m_f + RING_LEN - 1);
            exp_last  = exp_valid && (cyc == m_f + RING_LEN - 1);
            exp_data  = exp_valid ? sums[cyc - m_f] : 0;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (res_valid !== exp_valid || res_last !== exp_last) begin
                fails++;
                $display("FAIL %s (R6 framing) cyc %0d: valid/last got %0b/%0b expected %0b/%0b",
                         phase, cyc, res_valid, res_last, exp_valid, exp_last);
            end else if (exp_valid && (longint'(res_data) != exp_data)) begin
                fails++;
                $display("FAIL %s cyc %0d: res_data got %0d expected %0d",
                         phase, cyc, longint'(res_data), exp_data);
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic drive(input bit c, input bit v, input int a, input int b, input bit d);
        @(negedge clk);
        clr = c; in_valid = v; a_in = OP_W'(a); b_in = OP_W'(b); drain_start = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0);
    endtask

    task automatic push(input int a, input int b);
        drive(0, 1, a, b, 0);
    endtask

    task automatic drain_and_wait();
        drive(0, 0, 0, 0, 1);
        idle(RING_LEN + 6);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (60000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // ---------------- sequence ----------------
    initial begin
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        // R1: drain straight after reset reports zeros
        phase = "R1";
        drain_and_wait();

        // R3: products land round-robin, back to back
        phase = "R3";
        drive(1, 0, 0, 0, 0);
        for (int i = 1; i <= 6; i++) push(i, 100 * i);
        idle(4);
        drain_and_wait();

        // R4: gaps with in_valid low leave the ring unchanged (values on a_in ignored)
        phase = "R4";
        drive(1, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) begin
            push(-7 * i - 1, 3);
            drive(0, 0, 12345, 999, 0);
            drive(0, 0, -5000, 77, 0);
        end
        idle(3);
        drain_and_wait();

        // R2: extreme operands, exact full-width products
        phase = "R2";
        drive(1, 0, 0, 0, 0);
        push(-32768, -32768);
        push(-32768, 32767);
        push(32767, 32767);
        push(-1, -32768);
        push(-32768, -32768);
        idle(3);
        drain_and_wait();

        // R9: a long run of full-scale products inside the guard budget
        phase = "R9";
        drive(1, 0, 0, 0, 0);
        for (int i = 0; i < 400; i++) push(-32768, -32768);
        idle(3);
        drain_and_wait();

        // R5: clear drops the pair offered with it and any product in flight
        phase = "R5";
        drive(1, 0, 0, 0, 0);
        push(50, 50);
        push(60, 60);
        drive(1, 1, 9999, 9999, 0);
        push(2, 3);
        idle(3);
        drain_and_wait();

        // R6: drain requested right behind the last pair (k = e-1), and with it (k = e)
        phase = "R6";
        drive(1, 0, 0, 0, 0);
        push(11, 13);
        push(17, 19);
        drive(0, 0, 0, 0, 1);
        idle(RING_LEN + 6);
        push(23, 29);
        drive(0, 1, 31, 37, 1);
        idle(RING_LEN + 6);
        // k = e-2
        push(41, 43);
        idle(1);
        drive(0, 0, 0, 0, 1);
        idle(RING_LEN + 6);

        // R7: operands and repeat requests during a pending/active drain are ignored
        phase = "R7";
        push(5, 5);
        drive(0, 0, 0, 0, 1);
        for (int i = 0; i < RING_LEN + 4; i++) drive(0, 1, 1000 + i, 3, 1);
        idle(RING_LEN + 6);
        drain_and_wait();

        // R8: accumulation resumes after a drain at the next slot, on kept values
        phase = "R8";
        push(-3, 8);
        push(4, 4);
        push(-9, -9);
        idle(3);
        drain_and_wait();

        // R3: mixed random stream with random gaps and periodic drains
        phase = "R3";
        drive(1, 0, 0, 0, 0);
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
            push(int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768);
            if (i % 97 == 96) drain_and_wait();
        end
        idle(3);
        drain_and_wait();

        idle(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule